// File: doc/BRIEF.md
# Interrupt Source Conditioning Logic

This block sits between raw interrupt sources and a legacy programmable interrupt controller. It registers and conditions every line on the system clock. Each plug-and-play line has its own inverter select and its own trigger-mode select. A line in edge mode produces a one-cycle pulse when its polarity-corrected value rises. A line in level mode follows its corrected value. Each output carries a tag that tells the controller which trigger mode applies.

Each of the two disk-channel interrupt lines has its own native-mode enable. While the enable is clear, the line is a legacy edge-triggered request. While it is set, the line is active high at the pin and is folded into the shared PCI interrupt A. That shared request is level triggered and active low.

The keyboard pin and the mouse pin are each ANDed with the serial-IRQ slot value of the same number. The results feed a keyboard emulation path. Emulation only behaves when either the pin or its slot is held low. The controller, the emulation logic and the serial-IRQ decoder are outside this block.

Top module: `irq_cond_top`

## Requirements
- R1: While `rst` is high at a clock edge, every request output is 0, `pci_req_n` is 1, `kbd_emu` and `mse_emu` are 0, and every trigger tag is 0.
- R2: In level mode, a plug-and-play output equals its pin one cycle later when `pnp_keep_pol` is 1, and the inverse of its pin when it is 0.
- R3: `pnp_trig_level[i]` is 1 one cycle after `pnp_edge_mode[i]` is 0 (level), and 0 one cycle after it is 1 (edge).
- R4: In edge mode, a plug-and-play output is a single-cycle pulse, one cycle after the polarity-corrected input rises. A held or falling corrected input gives no pulse.
- R5: With `ide_native_en[i]` = 0, `ide_req[i]` pulses for one cycle, one cycle after `ide_pin[i]` rises, and `ide_trig_level[i]` is 0.
- R6: With `ide_native_en[i]` = 1, `ide_req[i]` stays 0 and `ide_trig_level[i]` is 1. A high `ide_pin[i]` drives `pci_req_n` low one cycle later.
- R7: The two native-mode enables are independent. One channel in native mode leaves the other channel's legacy behaviour unchanged.
- R8: `pci_a_n` low drives `pci_req_n` low one cycle later, and it stays low for as long as any merged source is active (level behaviour).
- R9: `kbd_emu` equals `kbd_pin` AND `kbd_slot`, and `mse_emu` equals `mse_pin` AND `mse_slot`, each one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pnp_pin | input | NUM_PNP | Plug-and-play interrupt pins |
| pnp_keep_pol | input | NUM_PNP | 1 keeps the pin polarity, 0 inverts it |
| pnp_edge_mode | input | NUM_PNP | 1 selects edge trigger, 0 selects level |
| ide_pin | input | NUM_IDE | Disk-channel interrupt pins, active high |
| ide_native_en | input | NUM_IDE | Per-channel native-mode enable |
| pci_a_n | input | 1 | Shared PCI interrupt A, active low |
| kbd_pin | input | 1 | Keyboard interrupt pin |
| mse_pin | input | 1 | Mouse interrupt pin |
| kbd_slot | input | 1 | Serial-IRQ keyboard slot value |
| mse_slot | input | 1 | Serial-IRQ mouse slot value |
| pnp_req | output | NUM_PNP | Conditioned plug-and-play requests |
| pnp_trig_level | output | NUM_PNP | Trigger tag, 1 for level |
| ide_req | output | NUM_IDE | Legacy disk-channel requests |
| ide_trig_level | output | NUM_IDE | Trigger tag, 1 for native (level) |
| pci_req_n | output | 1 | Merged level-triggered active-low request |
| kbd_emu | output | 1 | Keyboard input to the emulation path |
| mse_emu | output | 1 | Mouse input to the emulation path |

## Verification
A wrong edge-history bit shows up at the ports within one cycle. It appears either as an extra pulse, for example on a change of mode or of inverter setting, or as a missing pulse on the next rising corrected input. A stale native-enable or merge register shows up one cycle after the stimulus. It appears as a legacy pulse that should have been masked, or as `pci_req_n` staying high or staying low for the wrong duration. Every path is a single register stage, so no fault can stay hidden for longer than the cycle after the input that exposes it.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  function automatic logic fix_pol(input logic pin, input logic keep);
    return keep ? pin : ~pin;
  endfunction
endpackage

// File: rtl/irq_pol_trig.sv
module irq_pol_trig
  import irq_cond_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic keep_pol,
  input  logic edge_mode,
  input  logic line_off,
  output logic req,
  output logic trig_level
);
  logic  corr;
  logic  hist_q;
  trig_e mode_q;

  assign corr = fix_pol(pin, keep_pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b0;
      hist_q <= 1'b0;
      mode_q <= TRIG_EDGE;
    end else begin
      hist_q <= corr;
      mode_q <= edge_mode ? TRIG_EDGE : TRIG_LEVEL;
      if (line_off)
        req <= 1'b0;
      else if (edge_mode)
        req <= corr & ~hist_q;
      else
        req <= corr;
    end
  end

  assign trig_level = (mode_q == TRIG_LEVEL);

  // R4
  edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig_level && $past(req && !trig_level)) |-> !req);

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(line_off) && trig_level) |-> (req == ($past(pin) ~^ $past(keep_pol))));

  // R6
  line_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(line_off) |-> !req);
endmodule

// File: rtl/irq_native_merge.sv
module irq_native_merge #(
  parameter int NUM_IDE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDE-1:0] ide_pin,
  input  logic [NUM_IDE-1:0] native_en,
  input  logic               pci_a_n,
  output logic               pci_req_n
);
  logic any_native;

  assign any_native = |(ide_pin & native_en);

  always_ff @(posedge clk) begin
    if (rst) pci_req_n <= 1'b1;
    else     pci_req_n <= ~(~pci_a_n | any_native);
  end

  // R8
  pci_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pci_a_n)) |-> !pci_req_n);

  // R6
  native_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(ide_pin & native_en) != '0)) |-> !pci_req_n);
endmodule

// File: rtl/irq_emu_gate.sv
module irq_emu_gate (
  input  logic clk,
  input  logic rst,
  input  logic kbd_pin,
  input  logic mse_pin,
  input  logic kbd_slot,
  input  logic mse_slot,
  output logic kbd_emu,
  output logic mse_emu
);
  always_ff @(posedge clk) begin
    if (rst) begin
      kbd_emu <= 1'b0;
      mse_emu <= 1'b0;
    end else begin
      kbd_emu <= kbd_pin & kbd_slot;
      mse_emu <= mse_pin & mse_slot;
    end
  end

  // R9
  kbd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    kbd_emu |-> ($past(kbd_pin) && $past(kbd_slot)));

  // R9
  mse_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mse_emu |-> ($past(mse_pin) && $past(mse_slot)));
endmodule

// File: rtl/irq_cond_top.sv
module irq_cond_top #(
  parameter int NUM_PNP = 4,
  parameter int NUM_IDE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PNP-1:0] pnp_pin,
  input  logic [NUM_PNP-1:0] pnp_keep_pol,
  input  logic [NUM_PNP-1:0] pnp_edge_mode,
  input  logic [NUM_IDE-1:0] ide_pin,
  input  logic [NUM_IDE-1:0] ide_native_en,
  input  logic               pci_a_n,
  input  logic               kbd_pin,
  input  logic               mse_pin,
  input  logic               kbd_slot,
  input  logic               mse_slot,
  output logic [NUM_PNP-1:0] pnp_req,
  output logic [NUM_PNP-1:0] pnp_trig_level,
  output logic [NUM_IDE-1:0] ide_req,
  output logic [NUM_IDE-1:0] ide_trig_level,
  output logic               pci_req_n,
  output logic               kbd_emu,
  output logic               mse_emu
);
  logic [NUM_IDE-1:0] ide_edge_tag;

  for (genvar p = 0; p < NUM_PNP; p++) begin : g_pnp
    irq_pol_trig u_line (
      .clk        (clk),
      .rst        (rst),
      .pin        (pnp_pin[p]),
      .keep_pol   (pnp_keep_pol[p]),
      .edge_mode  (pnp_edge_mode[p]),
      .line_off   (1'b0),
      .req        (pnp_req[p]),
      .trig_level (pnp_trig_level[p])
    );
  end

  // Legacy disk channels: always edge, masked while native mode is on.
  for (genvar d = 0; d < NUM_IDE; d++) begin : g_ide
    irq_pol_trig u_line (
      .clk        (clk),
      .rst        (rst),
      .pin        (ide_pin[d]),
      .keep_pol   (1'b1),
      .edge_mode  (1'b1),
      .line_off   (ide_native_en[d]),
      .req        (ide_req[d]),
      .trig_level (ide_edge_tag[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ide_trig_level <= '0;
    else     ide_trig_level <= ide_native_en;
  end

  irq_native_merge #(.NUM_IDE(NUM_IDE)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .ide_pin   (ide_pin),
    .native_en (ide_native_en),
    .pci_a_n   (pci_a_n),
    .pci_req_n (pci_req_n)
  );

  irq_emu_gate u_emu (
    .clk      (clk),
    .rst      (rst),
    .kbd_pin  (kbd_pin),
    .mse_pin  (mse_pin),
    .kbd_slot (kbd_slot),
    .mse_slot (mse_slot),
    .kbd_emu  (kbd_emu),
    .mse_emu  (mse_emu)
  );

  // R5
  ide_edge_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (ide_edge_tag == '0));

  // R6
  native_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((ide_req & ide_trig_level) == '0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (pnp_req == '0 && ide_req == '0 && pci_req_n && !kbd_emu && !mse_emu));
endmodule

// File: tb/tb_irq_cond_top.sv
module tb_irq_cond_top;
  localparam int NP = 4;
  localparam int NI = 2;

  logic clk = 1'b0;
  logic rst;
  logic [NP-1:0] pnp_pin, pnp_keep_pol, pnp_edge_mode;
  logic [NI-1:0] ide_pin, ide_native_en;
  logic pci_a_n, kbd_pin, mse_pin, kbd_slot, mse_slot;
  logic [NP-1:0] pnp_req, pnp_trig_level;
  logic [NI-1:0] ide_req, ide_trig_level;
  logic pci_req_n, kbd_emu, mse_emu;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_cond_top #(.NUM_PNP(NP), .NUM_IDE(NI)) dut (
    .clk(clk), .rst(rst),
    .pnp_pin(pnp_pin), .pnp_keep_pol(pnp_keep_pol), .pnp_edge_mode(pnp_edge_mode),
    .ide_pin(ide_pin), .ide_native_en(ide_native_en), .pci_a_n(pci_a_n),
    .kbd_pin(kbd_pin), .mse_pin(mse_pin), .kbd_slot(kbd_slot), .mse_slot(mse_slot),
    .pnp_req(pnp_req), .pnp_trig_level(pnp_trig_level),
    .ide_req(ide_req), .ide_trig_level(ide_trig_level),
    .pci_req_n(pci_req_n), .kbd_emu(kbd_emu), .mse_emu(mse_emu)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change at the negative edge, registers load at the next positive edge,
  // and outputs are sampled 1 ns after that positive edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_at_negedge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    pnp_pin = '0; pnp_keep_pol = '1; pnp_edge_mode = '0;
    ide_pin = '0; ide_native_en = '0; pci_a_n = 1'b1;
    kbd_pin = 1'b1; mse_pin = 1'b1; kbd_slot = 1'b1; mse_slot = 1'b1;
    tick(); tick();
    chk("R1 pnp_req", pnp_req, 0);
    chk("R1 ide_req", ide_req, 0);
    chk("R1 pci_req_n", pci_req_n, 1);
    chk("R1 emu", {kbd_emu, mse_emu}, 0);
    chk("R1 tags", {pnp_trig_level, ide_trig_level}, 0);
    drive_at_negedge();
    rst = 1'b0; kbd_pin = 1'b0; mse_pin = 1'b0;
    tick();
  endtask

  task automatic t_polarity();
    drive_at_negedge();
    pnp_pin[0] = 1'b1; pnp_keep_pol[0] = 1'b1;
    tick();
    chk("R2 keep pin high", pnp_req[0], 1);
    drive_at_negedge();
    pnp_keep_pol[0] = 1'b0;
    tick();
    chk("R2 invert pin high", pnp_req[0], 0);
    drive_at_negedge();
    pnp_pin[0] = 1'b0;
    tick();
    chk("R2 invert pin low", pnp_req[0], 1);
    drive_at_negedge();
    pnp_keep_pol[0] = 1'b1;
    tick();
    chk("R2 keep pin low", pnp_req[0], 0);
  endtask

  task automatic t_trig_tag();
    drive_at_negedge();
    pnp_edge_mode = 4'b1010;
    tick();
    chk("R3 tag mixed", pnp_trig_level, 4'b0101);
    drive_at_negedge();
    pnp_edge_mode = 4'b0000;
    tick();
    chk("R3 tag all level", pnp_trig_level, 4'b1111);
  endtask

  task automatic t_edge();
    drive_at_negedge();
    pnp_edge_mode[1] = 1'b1; pnp_edge_mode[2] = 1'b1;
    tick();
    chk("R4 idle edge line", pnp_req[2:1], 0);
    drive_at_negedge();
    pnp_pin[1] = 1'b1;
    tick();
    chk("R4 pulse on rise", pnp_req[1], 1);
    tick();
    chk("R4 pulse ends", pnp_req[1], 0);
    tick();
    chk("R4 held high no pulse", pnp_req[1], 0);
    drive_at_negedge();
    pnp_pin[1] = 1'b0;
    tick();
    chk("R4 fall no pulse", pnp_req[1], 0);
    // Inverting a low pin makes the corrected value rise.
    drive_at_negedge();
    pnp_keep_pol[2] = 1'b0;
    tick();
    chk("R4 R2 inverted rise pulse", pnp_req[2], 1);
    tick();
    chk("R4 inverted pulse ends", pnp_req[2], 0);
    drive_at_negedge();
    pnp_keep_pol[2] = 1'b1; pnp_edge_mode = '0;
    tick();
  endtask

  task automatic t_ide_legacy();
    drive_at_negedge();
    ide_pin[0] = 1'b1;
    tick();
    chk("R5 legacy pulse", ide_req[0], 1);
    chk("R5 legacy tag edge", ide_trig_level, 0);
    chk("R5 no merge", pci_req_n, 1);
    tick();
    chk("R5 legacy pulse ends", ide_req[0], 0);
    drive_at_negedge();
    ide_pin[0] = 1'b0;
    tick();
  endtask

  task automatic t_native();
    drive_at_negedge();
    ide_native_en[1] = 1'b1; ide_pin[1] = 1'b1;
    tick();
    chk("R6 native masked", ide_req[1], 0);
    chk("R6 native tag", ide_trig_level, 2'b10);
    chk("R6 merged low", pci_req_n, 0);
    drive_at_negedge();
    ide_pin[0] = 1'b1;
    tick();
    chk("R7 other channel legacy pulse", ide_req[0], 1);
    chk("R7 native still masked", ide_req[1], 0);
    drive_at_negedge();
    ide_pin[1] = 1'b0;
    tick();
    chk("R6 merged release", pci_req_n, 1);
    chk("R7 legacy pulse ends", ide_req[0], 0);
    drive_at_negedge();
    ide_pin[0] = 1'b0; ide_native_en = '0;
    tick();
  endtask

  task automatic t_pci();
    drive_at_negedge();
    pci_a_n = 1'b0;
    tick();
    chk("R8 pci low", pci_req_n, 0);
    tick(); tick();
    chk("R8 pci held low", pci_req_n, 0);
    drive_at_negedge();
    pci_a_n = 1'b1;
    tick();
    chk("R8 pci release", pci_req_n, 1);
  endtask

  task automatic t_emu();
    for (int v = 0; v < 16; v++) begin
      drive_at_negedge();
      {kbd_pin, kbd_slot, mse_pin, mse_slot} = v[3:0];
      tick();
      chk("R9 kbd gate", kbd_emu, 32'(v[3] & v[2]));
      chk("R9 mse gate", mse_emu, 32'(v[1] & v[0]));
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_polarity();
    t_trig_tag();
    t_edge();
    t_ide_legacy();
    t_native();
    t_pci();
    t_emu();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule